// File: doc/BRIEF.md
# Triple-Error Locator and Serial Corrector for a 15-bit Binary BCH Word

This block finishes the decoding of a 15-bit binary BCH word that can correct up to three errors. It is given the received word and the six syndromes over GF(16) in one start cycle. A Berlekamp-Massey solver for binary codes runs three update steps and produces an error-locator polynomial of degree at most three.

A root search then tests one bit position per clock. It first evaluates the locator at alpha^1 and, after fifteen steps, at alpha^15 = 1. A zero result at alpha^k marks position 15-k as wrong. The positions are therefore visited from the highest-degree bit down to bit 0.

When the count of roots found equals the locator length, the flagged bits are inverted. Otherwise the word is passed on unchanged and a failure flag is raised. The word then leaves serially, most significant bit first, under a valid strobe. A surrounding decoder supplies the syndromes and takes the corrected bit stream.

Top module: `bch_locator_corrector`

## Requirements
- R1: After a synchronous reset, vdout, dout and dec_fail are all 0 until a word has been decoded.
- R2: Each accepted start yields exactly 15 consecutive cycles with vdout high. The first bit driven is the coefficient of x^14, which is bit 14 of rx_word, and the last is bit 0. vdout then returns low.
- R3: When all six syndromes are zero, the output word equals rx_word and dec_fail stays 0.
- R4: A single bit error at any position, 0 through 14, is corrected.
- R5: Two bit errors at any two positions are corrected.
- R6: Three bit errors are corrected, including the case where they sit at the extreme positions 14 and 0.
- R7: The received word 0x65A4 (error pattern x^13+x^9+x^3), with its syndromes, is corrected to 0x47AC.
- R8: If the locator length exceeds 3, or the number of roots found differs from that length, dout carries rx_word unchanged and dec_fail is 1 on every valid cycle. For correctable words dec_fail is 0. dec_fail is never 1 while vdout is low.
- R9: A start pulse that arrives while a word is being decoded or emitted is ignored. Only the first word is emitted and no extra frame follows.
- R10: dout is 0 on every cycle where vdout is 0.
- R11: Syndrome S_i (i = 1..6) is read from syndromes[4*i-1 : 4*i-4]. Field elements use the basis of x^4+x+1, with alpha encoded as 4'b0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to decode the word and syndromes present this cycle |
| rx_word | input | 15 | Received word, bit j = coefficient of x^j |
| syndromes | input | 24 | Six 4-bit syndromes, S1 in the lowest nibble |
| dout | output | 1 | Corrected bit, highest degree first |
| vdout | output | 1 | High while dout carries a valid bit |
| dec_fail | output | 1 | High during a frame whose word could not be corrected |

## Verification
Some properties hold on every cycle and are checked by assertions. dout must be quiet outside a frame, and every valid burst must be exactly 15 cycles long. dec_fail may appear only inside a frame and must hold steady for the whole frame, and the outputs must be idle right after reset.

Other behaviour can only be shown by the bench's scenarios. These cover whether the right bits are flipped for one, two and three errors (including the worked word) and whether bit order runs from high degree to low. They also cover whether an inconsistent locator triggers pass-through and whether a start pulse during a busy decode is discarded.

// File: rtl/bch_gf_pkg.sv
package bch_gf_pkg;
  localparam int GF_M = 4;
  localparam int GF_N = (1 << GF_M) - 1;
  // low-order terms of the field polynomial x^4 + x + 1
  localparam logic [GF_M-1:0] GF_RED = 4'b0011;

  typedef logic [GF_M-1:0] gf_t;

  function automatic gf_t gf_mul(gf_t a, gf_t b);
    gf_t acc;
    gf_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < GF_M; i++) begin
      if (b[i]) acc = acc ^ sh;
      if (sh[GF_M-1]) sh = {sh[GF_M-2:0], 1'b0} ^ GF_RED;
      else            sh = {sh[GF_M-2:0], 1'b0};
    end
    return acc;
  endfunction

  function automatic gf_t gf_apow(int e);
    gf_t r;
    int  em;
    r  = gf_t'(1);
    em = e % GF_N;
    for (int i = 0; i < GF_N; i++)
      if (i < em) r = gf_mul(r, gf_t'(2));
    return r;
  endfunction

  // a^(N-1) is the inverse of a nonzero element; 0 maps to 0
  function automatic gf_t gf_inv(gf_t a);
    gf_t r;
    r = gf_t'(1);
    for (int i = 0; i < GF_N - 1; i++) r = gf_mul(r, a);
    return r;
  endfunction
endpackage

// File: rtl/bch_bm_solver.sv
module bch_bm_solver
  import bch_gf_pkg::*;
#(
  parameter int T = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [2*T*GF_M-1:0]       synd_in,
  output logic [(T+1)*GF_M-1:0]     lam_flat,
  output logic [$clog2(2*T+2)-1:0]  len_o,
  output logic                      done
);
  localparam int M  = GF_M;
  localparam int LW = $clog2(2*T+2);
  localparam int KW = $clog2(T+1);

  logic [2*T*M-1:0] synd_q;
  gf_t              lam_q [T+1];
  gf_t              bp_q  [T+1];
  gf_t              lam_nx[T+1];
  gf_t              bp_nx [T+1];
  logic [LW-1:0]    len_q, len_nx;
  logic [KW-1:0]    k_q;
  logic             run_q;
  gf_t              delta, dinv;
  logic             grow;

  // discrepancy for odd step 2k+1 and the length-changing update
  always_comb begin
    delta = '0;
    for (int i = 0; i <= T; i++) begin
      int idx;
      idx = 2 * int'(k_q) + 1 - i;
      if (idx >= 1 && idx <= 2*T)
        delta = delta ^ gf_mul(lam_q[i], synd_q[(idx-1)*M +: M]);
    end
    dinv = gf_inv(delta);
    grow = (delta != '0) && (int'(len_q) <= int'(k_q));
    for (int i = 0; i <= T; i++) begin
      lam_nx[i] = lam_q[i];
      if (i > 0) lam_nx[i] = lam_q[i] ^ gf_mul(delta, bp_q[i-1]);
      bp_nx[i] = '0;
      if (grow) begin
        if (i > 0) bp_nx[i] = gf_mul(dinv, lam_q[i-1]);
      end else begin
        if (i > 1) bp_nx[i] = bp_q[i-2];
      end
    end
    len_nx = grow ? LW'(2 * int'(k_q) + 1 - int'(len_q)) : len_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      synd_q <= '0;
      len_q  <= '0;
      k_q    <= '0;
      run_q  <= 1'b0;
      done   <= 1'b0;
      for (int i = 0; i <= T; i++) begin
        lam_q[i] <= '0;
        bp_q[i]  <= '0;
      end
    end else begin
      done <= 1'b0;
      if (start) begin
        synd_q <= synd_in;
        len_q  <= '0;
        k_q    <= '0;
        run_q  <= 1'b1;
        for (int i = 0; i <= T; i++) begin
          lam_q[i] <= (i == 0) ? gf_t'(1) : '0;
          bp_q[i]  <= (i == 0) ? gf_t'(1) : '0;
        end
      end else if (run_q) begin
        lam_q <= lam_nx;
        bp_q  <= bp_nx;
        len_q <= len_nx;
        k_q   <= k_q + 1'b1;
        if (k_q == KW'(T-1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  for (genvar gi = 0; gi <= T; gi++) begin : g_lam_out
    assign lam_flat[gi*M +: M] = lam_q[gi];
  end
  assign len_o = len_q;
endmodule

// File: rtl/bch_chien_search.sv
module bch_chien_search
  import bch_gf_pkg::*;
#(
  parameter int T = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [(T+1)*GF_M-1:0]     lam_flat,
  input  logic [$clog2(2*T+2)-1:0]  len_in,
  output logic [GF_N-1:0]           flags_o,
  output logic                      fail_o,
  output logic                      done
);
  localparam int M  = GF_M;
  localparam int N  = GF_N;
  localparam int LW = $clog2(2*T+2);
  localparam int CW = $clog2(N+1);

  gf_t           lam0_q;
  gf_t           term_q [1:T];
  logic [LW-1:0] len_q;
  logic [CW-1:0] pos_q;
  logic [CW-1:0] roots_q;
  logic          run_q;
  gf_t           sum;
  logic          hit;

  // term i steps by alpha^i, so step k evaluates the locator at alpha^k
  for (genvar gi = 1; gi <= T; gi++) begin : g_term
    localparam gf_t STEP = gf_apow(gi);
    always_ff @(posedge clk) begin
      if (rst)        term_q[gi] <= '0;
      else if (start) term_q[gi] <= gf_mul(lam_flat[gi*M +: M], STEP);
      else if (run_q) term_q[gi] <= gf_mul(term_q[gi], STEP);
    end
  end

  always_comb begin
    sum = lam0_q;
    for (int i = 1; i <= T; i++) sum = sum ^ term_q[i];
    hit = run_q && (sum == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lam0_q  <= '0;
      len_q   <= '0;
      pos_q   <= '0;
      roots_q <= '0;
      run_q   <= 1'b0;
      flags_o <= '0;
      fail_o  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        lam0_q  <= lam_flat[M-1:0];
        len_q   <= len_in;
        pos_q   <= '0;
        roots_q <= '0;
        run_q   <= 1'b1;
        flags_o <= '0;
        fail_o  <= 1'b0;
      end else if (run_q) begin
        flags_o <= {flags_o[N-2:0], hit};
        roots_q <= roots_q + CW'(hit);
        pos_q   <= pos_q + 1'b1;
        if (pos_q == CW'(N-1)) begin
          run_q  <= 1'b0;
          done   <= 1'b1;
          fail_o <= (int'(len_q) > T) ||
                    ((int'(roots_q) + int'(hit)) != int'(len_q));
        end
      end
    end
  end
endmodule

// File: rtl/bch_serial_out.sv
module bch_serial_out #(
  parameter int N = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [N-1:0] word_in,
  input  logic         fail_in,
  output logic         dout,
  output logic         vdout,
  output logic         dec_fail,
  output logic         finished
);
  localparam int CW = $clog2(N+1);

  logic [N-1:0]  sh_q;
  logic [CW-1:0] left_q;
  logic          fail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      left_q   <= '0;
      fail_q   <= 1'b0;
      dout     <= 1'b0;
      vdout    <= 1'b0;
      dec_fail <= 1'b0;
      finished <= 1'b0;
    end else begin
      finished <= 1'b0;
      if (left_q != '0) begin
        dout     <= sh_q[N-1];
        vdout    <= 1'b1;
        dec_fail <= fail_q;
        sh_q     <= {sh_q[N-2:0], 1'b0};
        left_q   <= left_q - 1'b1;
        finished <= (left_q == CW'(1));
      end else begin
        dout     <= 1'b0;
        vdout    <= 1'b0;
        dec_fail <= 1'b0;
        if (start) begin
          sh_q   <= word_in;
          fail_q <= fail_in;
          left_q <= CW'(N);
        end
      end
    end
  end
endmodule

// File: rtl/bch_locator_corrector.sv
module bch_locator_corrector
  import bch_gf_pkg::*;
#(
  parameter int T = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [GF_N-1:0]       rx_word,
  input  logic [2*T*GF_M-1:0]   syndromes,
  output logic                  dout,
  output logic                  vdout,
  output logic                  dec_fail
);
  localparam int N  = GF_N;
  localparam int LW = $clog2(2*T+2);

  logic                  busy_q;
  logic                  accept;
  logic [N-1:0]          rx_q;
  logic [(T+1)*GF_M-1:0] lam_flat;
  logic [LW-1:0]         lam_len;
  logic                  bm_done;
  logic [N-1:0]          err_flags;
  logic                  search_fail;
  logic                  search_done;
  logic [N-1:0]          fixed_word;
  logic                  out_finished;

  assign accept = start && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      if (accept) begin
        busy_q <= 1'b1;
        rx_q   <= rx_word;
      end else if (out_finished) begin
        busy_q <= 1'b0;
      end
    end
  end

  bch_bm_solver #(.T(T)) i_bm (
    .clk(clk), .rst(rst), .start(accept), .synd_in(syndromes),
    .lam_flat(lam_flat), .len_o(lam_len), .done(bm_done)
  );

  bch_chien_search #(.T(T)) i_search (
    .clk(clk), .rst(rst), .start(bm_done), .lam_flat(lam_flat),
    .len_in(lam_len), .flags_o(err_flags), .fail_o(search_fail),
    .done(search_done)
  );

  assign fixed_word = search_fail ? rx_q : (rx_q ^ err_flags);

  bch_serial_out #(.N(N)) i_out (
    .clk(clk), .rst(rst), .start(search_done), .word_in(fixed_word),
    .fail_in(search_fail), .dout(dout), .vdout(vdout),
    .dec_fail(dec_fail), .finished(out_finished)
  );
endmodule

// File: rtl/bch_locator_corrector_chk.sv
module bch_locator_corrector_chk #(
  parameter int N = 15
) (
  input logic clk,
  input logic rst,
  input logic dout,
  input logic vdout,
  input logic dec_fail
);
  localparam int RW = $clog2(N+2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)        run_q <= '0;
    else if (vdout) run_q <= run_q + 1'b1;
    else            run_q <= '0;
  end

  a_r10_dout_quiet: assert property (@(posedge clk) disable iff (rst)
    !vdout |-> !dout);
  a_r2_burst_cap: assert property (@(posedge clk) disable iff (rst)
    vdout |-> (int'(run_q) < N));
  a_r2_burst_full: assert property (@(posedge clk) disable iff (rst)
    $fell(vdout) |-> (int'(run_q) == N));
  a_r8_fail_in_frame: assert property (@(posedge clk) disable iff (rst)
    dec_fail |-> vdout);
  a_r8_fail_steady: assert property (@(posedge clk) disable iff (rst)
    (vdout && $past(vdout)) |-> $stable(dec_fail));
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!vdout && !dec_fail));
endmodule

bind bch_locator_corrector bch_locator_corrector_chk #(.N(bch_gf_pkg::GF_N)) i_chk (
  .clk(clk), .rst(rst), .dout(dout), .vdout(vdout), .dec_fail(dec_fail)
);

// File: tb/test_bch_locator_corrector.sv
module test_bch_locator_corrector;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [14:0] rx_word = '0;
  logic [23:0] syndromes = '0;
  logic        dout, vdout, dec_fail;

  int n_checks = 0;
  int n_fail   = 0;
  bit ended    = 0;

  always #5 clk = ~clk;

  bch_locator_corrector i_bch_locator_corrector (
    .clk(clk), .rst(rst), .start(start), .rx_word(rx_word),
    .syndromes(syndromes), .dout(dout), .vdout(vdout), .dec_fail(dec_fail)
  );

  // field arithmetic over x^4+x+1, alpha = 4'b0010 (R11)
  function automatic logic [3:0] fmul(logic [3:0] a, logic [3:0] b);
    logic [3:0] p = '0;
    logic [3:0] s = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) p ^= s;
      s = s[3] ? ({s[2:0], 1'b0} ^ 4'b0011) : {s[2:0], 1'b0};
    end
    return p;
  endfunction

  function automatic logic [3:0] apow(int e);
    logic [3:0] r = 4'd1;
    for (int i = 0; i < e % 15; i++) r = fmul(r, 4'd2);
    return r;
  endfunction

  function automatic logic [23:0] synd_of(logic [14:0] r);
    logic [23:0] s = '0;
    for (int i = 1; i <= 6; i++) begin
      logic [3:0] acc = '0;
      for (int j = 0; j < 15; j++) if (r[j]) acc ^= apow(i * j);
      s[(i-1)*4 +: 4] = acc;
    end
    return s;
  endfunction

  function automatic logic [14:0] encode(logic [4:0] m);
    logic [14:0] v = {m, 10'b0};
    for (int b = 14; b >= 10; b--) if (v[b]) v ^= (15'h537 << (b - 10));
    return {m, v[9:0]};
  endfunction

  task automatic check(input bit ok, input string req, input int got, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic pulse_start(input logic [14:0] rx, input logic [23:0] syn);
    @(negedge clk);
    start = 1'b1; rx_word = rx; syndromes = syn;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic capture(input logic [14:0] exp_word, input bit exp_fail, input string req);
    int          waitc = 0;
    int          vcount = 0;
    int          bad_fail = 0;
    logic [14:0] got = '0;
    while (!vdout && waitc < 80) begin @(negedge clk); waitc++; end
    for (int b = 0; b < 15; b++) begin
      if (vdout) vcount++;
      got[14-b] = dout;
      if (dec_fail !== exp_fail) bad_fail++;
      @(negedge clk);
    end
    check(vcount == 15 && !vdout, {req, " R2 burst"}, vcount, 15);
    check(got == exp_word, {req, " word"}, got, exp_word);
    check(bad_fail == 0, {req, " R8 dec_fail"}, bad_fail, 0);
  endtask

  task automatic run_word(input logic [14:0] rx, input logic [14:0] exp_word, input string req);
    pulse_start(rx, synd_of(rx));
    capture(exp_word, 1'b0, req);
  endtask

  task automatic t_reset();
    check(!vdout && !dout && !dec_fail, "R1 reset outputs", {vdout, dout, dec_fail}, 0);
  endtask

  task automatic t_worked();
    check(encode(5'b10001) == 15'h47AC, "R7 bench codeword", encode(5'b10001), 15'h47AC);
    run_word(15'h65A4, 15'h47AC, "R7 worked example");
  endtask

  task automatic t_clean();
    run_word(encode(5'b10110), encode(5'b10110), "R3 clean word");
    run_word(15'h0000, 15'h0000, "R3 all-zero word");
  endtask

  task automatic t_single();
    logic [14:0] c = encode(5'b01101);
    run_word(c ^ 15'h0001, c, "R4 error at bit 0");
    run_word(c ^ 15'h0020, c, "R4 error at bit 5");
    run_word(c ^ 15'h4000, c, "R4 error at bit 14");
  endtask

  task automatic t_double();
    logic [14:0] c = encode(5'b11011);
    run_word(c ^ 15'h1002, c, "R5 errors at 12 and 1");
    run_word(c ^ 15'h0300, c, "R5 errors at 9 and 8");
  endtask

  task automatic t_triple();
    logic [14:0] c = encode(5'b00111);
    run_word(c ^ 15'h4081, c, "R6 errors at 14, 7, 0");
    run_word(c ^ 15'h0C10, c, "R6 errors at 11, 10, 4");
  endtask

  task automatic t_uncorrectable();
    // S3 = alpha, S6 = alpha^2, rest zero: locator 1 + alpha x^3 with no roots
    pulse_start(15'h1234, 24'h400200);
    capture(15'h1234, 1'b1, "R8 pass-through");
  endtask

  task automatic t_busy();
    logic [14:0] a = encode(5'b10101) ^ 15'h0104;
    logic [14:0] b = encode(5'b01010);
    int          extra = 0;
    int          noisy = 0;
    pulse_start(a, synd_of(a));
    repeat (2) @(negedge clk);
    pulse_start(b, synd_of(b));
    capture(encode(5'b10101), 1'b0, "R9 first word kept");
    for (int i = 0; i < 60; i++) begin
      if (vdout) extra++;
      if (dout) noisy++;
      @(negedge clk);
    end
    check(extra == 0, "R9 no second frame", extra, 0);
    check(noisy == 0, "R10 dout idle", noisy, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!ended) begin
      ended = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_worked();
    t_clean();
    t_single();
    t_double();
    t_triple();
    t_uncorrectable();
    t_busy();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule